// File: doc/BRIEF.md
# Packed Variable Shift Unit

This execute-stage block handles one secondary opcode group of a media extension. It decodes a 32-bit instruction word and shifts two extension register values by the same variable amount. The amount comes from the four least significant bits of a general-purpose register. Each extension register is treated either as a single 32-bit word or as two independent 16-bit halves. The shift kinds are logical left, logical right and arithmetic right.

The block drives the index of the general-purpose register to read, without a register stage. The two shifted results, their destination indices, a write strobe and a reserved-instruction flag all come out of registers, one cycle after an accepted instruction. A result goes back to the extension register it was read from. Undefined encodings in the group raise the reserved flag and write nothing. Register files and fetch sit outside the block.

Top module: `vshift_unit`

## Requirements
- R1: The block acts only when `in_valid` is high and instruction bits 5..0 equal 0x36. Any other word, or a cycle with `in_valid` low, gives `out_we` and `out_rsv` both low on the next cycle, and the result and index outputs keep their values.
- R2: Instruction bits 20..18 select the operation. The codes are: 0 = 32-bit left, 1 = 32-bit logical right, 3 = 32-bit arithmetic right, 4 = 16-bit-lane left, 5 = 16-bit-lane logical right, 7 = 16-bit-lane arithmetic right.
- R3: Codes 2 and 6 in bits 20..18 set `out_rsv` for one cycle with `out_we` low, and all result and index outputs keep their previous values.
- R4: The first register index is taken from bits 13..10 and the second from bits 17..14. Both are registered to `out_xra_idx` and `out_xrd_idx`. Bits 25..21 appear on `gpr_rd_idx` in the same cycle.
- R5: The shift amount is `gpr_val[3:0]` (0 to 15). Bits 31..4 of `gpr_val` have no effect.
- R6: In 32-bit modes both registers are shifted as whole words. Logical modes fill with zeros. The arithmetic mode fills with copies of bit 31.
- R7: In 16-bit-lane modes bits 15..0 and bits 31..16 are shifted separately. Bits never pass between lanes. Bits shifted above a lane's top are lost. The arithmetic mode fills each lane with copies of its own top bit (bit 15 or bit 31).
- R8: A shift amount of 0 returns both source values unchanged in all six operations.
- R9: For a legal operation, `out_we` is high for exactly the cycle after the accepted instruction, and the results appear in that same cycle.
- R10: While `rst_n` is low at a clock edge, all registered outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| xra_val | input | 32 | Value of the first extension register |
| xrd_val | input | 32 | Value of the second extension register |
| gpr_val | input | 32 | General-purpose register holding the shift amount |
| gpr_rd_idx | output | 5 | Index of the general-purpose register to read (combinational) |
| out_we | output | 1 | Write-back strobe for both results |
| out_rsv | output | 1 | Reserved-instruction indication |
| out_xra_idx | output | 4 | Destination index of the first result |
| out_xrd_idx | output | 4 | Destination index of the second result |
| out_xra_res | output | 32 | Shifted first register value |
| out_xrd_res | output | 32 | Shifted second register value |

## Verification
The bench drives every shift amount through all six operations. It uses data with negative halves, so a unit that sign-extended the whole word instead of each lane would put wrong fill bits into the low half. A unit that let bits cross lanes would corrupt the high half on left shifts. A unit that used bit 4 of the amount would shift too far when the upper bits of `gpr_val` are random. Reserved codes 2 and 6 and a foreign major opcode are checked to leave the outputs unchanged. A decoder that mapped the gap codes onto a real shift would write, or would fail to flag the trap.

// File: rtl/vshift_pkg.sv
// Package: shared field positions, shift kinds and the decoded-instruction
// record for the packed variable shift unit.
package vshift_pkg;

    localparam int INSTR_W   = 32;
    localparam int XR_IDX_W  = 4;
    localparam int GPR_IDX_W = 5;
    localparam int SUB_W     = 3;
    localparam int MAJ_W     = 6;

    // Bit positions of the instruction fields.
    localparam int MAJ_LSB   = 0;
    localparam int XRA_LSB   = 10;
    localparam int XRD_LSB   = 14;
    localparam int SUB_LSB   = 18;
    localparam int RS_LSB    = 21;

    typedef enum logic [1:0] {
        SH_LEFT   = 2'd0,
        SH_LRIGHT = 2'd1,
        SH_ARIGHT = 2'd2
    } shift_kind_e;

    typedef struct packed {
        logic                 legal;
        logic                 rsv;
        logic                 quad;
        shift_kind_e          kind;
        logic [XR_IDX_W-1:0]  a_idx;
        logic [XR_IDX_W-1:0]  d_idx;
        logic [GPR_IDX_W-1:0] rs_idx;
    } dec_t;

endpackage

// File: rtl/vshift_decode.sv
// Decoder: recognises the major opcode and splits the sub-opcode into
// lane mode and shift kind. Assumes the sub-opcode is bits 20..18, with
// bit 2 selecting 16-bit lanes and bits 1..0 selecting the kind
// (00 left, 01 logical right, 11 arithmetic right, 10 undefined).
module vshift_decode
    import vshift_pkg::*;
#(
    parameter logic [MAJ_W-1:0] MAJOR_VAL = 6'h36
) (
    input  logic               valid,
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    logic             hit;
    logic [SUB_W-1:0] sub;

    // Field extraction and operation classification.
    always_comb begin
        hit        = valid && (instr[MAJ_LSB +: MAJ_W] == MAJOR_VAL);
        sub        = instr[SUB_LSB +: SUB_W];
        dec.quad   = sub[2];
        dec.a_idx  = instr[XRA_LSB +: XR_IDX_W];
        dec.d_idx  = instr[XRD_LSB +: XR_IDX_W];
        dec.rs_idx = instr[RS_LSB +: GPR_IDX_W];
        unique case (sub[1:0])
            2'b00:   dec.kind = SH_LEFT;
            2'b01:   dec.kind = SH_LRIGHT;
            2'b11:   dec.kind = SH_ARIGHT;
            default: dec.kind = SH_LEFT;
        endcase
        dec.rsv   = hit && (sub[1:0] == 2'b10);
        dec.legal = hit && (sub[1:0] != 2'b10);
    end

endmodule

// File: rtl/vshift_lane.sv
// Lane shifter: shifts one W-bit field by 0..2**AMT_W-1 positions.
// Assumes the caller has already isolated the lane, so right shifts fill
// from this lane's own top bit (arithmetic) or with zeros (logical).
module vshift_lane
    import vshift_pkg::*;
#(
    parameter int W     = 16,
    parameter int AMT_W = 4
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    input  shift_kind_e      kind,
    output logic [W-1:0]     dout
);

    logic signed [W-1:0] sdin;
    assign sdin = $signed(din);

    // Barrel shift for the selected kind; overflow bits drop off at width W.
    always_comb begin
        unique case (kind)
            SH_LEFT:   dout = din << amt;
            SH_LRIGHT: dout = din >> amt;
            SH_ARIGHT: dout = sdin >>> amt;
            default:   dout = din;
        endcase
    end

endmodule

// File: rtl/vshift_word.sv
// Word shifter: one register value either as a single DATA_W lane or as
// DATA_W/LANE_W independent lanes, with the lane mode picked per operation.
// Assumes DATA_W is a whole multiple of LANE_W.
module vshift_word
    import vshift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 16,
    parameter int AMT_W  = 4
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    input  shift_kind_e       kind,
    input  logic              quad,
    output logic [DATA_W-1:0] dout
);

    localparam int N_LANES = DATA_W / LANE_W;

    logic [DATA_W-1:0] wide_res;
    logic [DATA_W-1:0] lane_res;

    vshift_lane #(.W(DATA_W), .AMT_W(AMT_W)) u_wide (
        .din  (din),
        .amt  (amt),
        .kind (kind),
        .dout (wide_res)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        vshift_lane #(.W(LANE_W), .AMT_W(AMT_W)) u_lane (
            .din  (din[g*LANE_W +: LANE_W]),
            .amt  (amt),
            .kind (kind),
            .dout (lane_res[g*LANE_W +: LANE_W])
        );
    end

    // Choose the whole-word or the per-lane result.
    always_comb begin
        dout = quad ? lane_res : wide_res;
    end

endmodule

// File: rtl/vshift_unit.sv
// Top: packed variable shift unit. Decodes the instruction, shifts both
// extension register values by gpr_val[AMT_W-1:0] and registers the
// results for write-back one cycle later. Assumes the register files
// return xra_val, xrd_val and gpr_val in the same cycle as the instruction.
module vshift_unit
    import vshift_pkg::*;
#(
    parameter int               DATA_W    = 32,
    parameter int               LANE_W    = 16,
    parameter int               AMT_W     = 4,
    parameter logic [MAJ_W-1:0] MAJOR_VAL = 6'h36
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [DATA_W-1:0]    xra_val,
    input  logic [DATA_W-1:0]    xrd_val,
    input  logic [DATA_W-1:0]    gpr_val,
    output logic [GPR_IDX_W-1:0] gpr_rd_idx,
    output logic                 out_we,
    output logic                 out_rsv,
    output logic [XR_IDX_W-1:0]  out_xra_idx,
    output logic [XR_IDX_W-1:0]  out_xrd_idx,
    output logic [DATA_W-1:0]    out_xra_res,
    output logic [DATA_W-1:0]    out_xrd_res
);

    dec_t              dec;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] a_shift;
    logic [DATA_W-1:0] d_shift;

    vshift_decode #(.MAJOR_VAL(MAJOR_VAL)) u_dec (
        .valid (in_valid),
        .instr (instr),
        .dec   (dec)
    );

    // Amount comes from the low bits of the GPR only.
    assign amt        = gpr_val[AMT_W-1:0];
    assign gpr_rd_idx = dec.rs_idx;

    vshift_word #(.DATA_W(DATA_W), .LANE_W(LANE_W), .AMT_W(AMT_W)) u_word_a (
        .din  (xra_val),
        .amt  (amt),
        .kind (dec.kind),
        .quad (dec.quad),
        .dout (a_shift)
    );

    vshift_word #(.DATA_W(DATA_W), .LANE_W(LANE_W), .AMT_W(AMT_W)) u_word_d (
        .din  (xrd_val),
        .amt  (amt),
        .kind (dec.kind),
        .quad (dec.quad),
        .dout (d_shift)
    );

    // Strobes: one-cycle write or trap indication per accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_we  <= 1'b0;
            out_rsv <= 1'b0;
        end else begin
            out_we  <= dec.legal;
            out_rsv <= dec.rsv;
        end
    end

    // Result and index registers load only on a legal operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_xra_idx <= '0;
            out_xrd_idx <= '0;
            out_xra_res <= '0;
            out_xrd_res <= '0;
        end else if (dec.legal) begin
            out_xra_idx <= dec.a_idx;
            out_xrd_idx <= dec.d_idx;
            out_xra_res <= a_shift;
            out_xrd_res <= d_shift;
        end
    end

endmodule

// File: rtl/vshift_unit_chk.sv
// Checker: timing properties of vshift_unit, attached through bind.
// Decodes the instruction on its own, from the field positions alone.
module vshift_unit_chk
    import vshift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [INSTR_W-1:0] instr,
    input logic [DATA_W-1:0]  xra_val,
    input logic [DATA_W-1:0]  xrd_val,
    input logic [DATA_W-1:0]  gpr_val,
    input logic               out_we,
    input logic               out_rsv,
    input logic [3:0]         out_xra_idx,
    input logic [DATA_W-1:0]  out_xra_res,
    input logic [DATA_W-1:0]  out_xrd_res
);

    logic       c_hit;
    logic [2:0] c_sub;
    logic       c_gap;

    // Independent view of the opcode fields.
    always_comb begin
        c_hit = in_valid && (instr[5:0] == 6'h36);
        c_sub = instr[20:18];
        c_gap = (c_sub == 3'd2) || (c_sub == 3'd6);
    end

    a_r1_no_action: assert property (@(posedge clk) disable iff (!rst_n)
        !c_hit |=> (!out_we && !out_rsv));

    a_r3_gap_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hit && c_gap) |=> (out_rsv && !out_we));

    a_r3_no_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !out_we |-> ($stable(out_xra_res) && $stable(out_xrd_res)));

    a_r4_dest_index: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hit && !c_gap) |=> (out_xra_idx == $past(instr[13:10])));

    a_r6_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hit && c_sub == 3'd3 && xra_val[DATA_W-1]) |=> out_xra_res[DATA_W-1]);

    a_r8_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hit && !c_gap && gpr_val[3:0] == 4'd0) |=>
        (out_xra_res == $past(xra_val) && out_xrd_res == $past(xrd_val)));

    a_r9_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hit && !c_gap) |=> (out_we && !out_rsv));

endmodule

bind vshift_unit vshift_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/vshift_unit_tb.sv
`timescale 1ns/1ps
module vshift_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] xra_val = '0;
    logic [31:0] xrd_val = '0;
    logic [31:0] gpr_val = '0;
    logic [4:0]  gpr_rd_idx;
    logic        out_we, out_rsv;
    logic [3:0]  out_xra_idx, out_xrd_idx;
    logic [31:0] out_xra_res, out_xrd_res;

    always #2.5 clk = ~clk;

    vshift_unit u_dut (.*);

    typedef struct {
        bit          we;
        bit          rsv;
        logic [3:0]  ai, di;
        logic [31:0] ra, rd;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          n_cmp = 0, n_bad = 0;
    logic [3:0]  m_ai = '0, m_di = '0;
    logic [31:0] m_ra = '0, m_rd = '0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural model of one register value: integer arithmetic per lane.
    function automatic logic [31:0] ref_shift(logic [31:0] x, int amt, int sub);
        int          kind = sub & 3;
        logic [31:0] res = '0;
        if (sub < 4) begin
            longint v = longint'(x);
            longint r;
            if (kind == 3 && x[31]) v = v - 64'sd4294967296;
            r = (kind == 0) ? (v << amt) : (v >>> amt);
            res = r[31:0];
        end else begin
            for (int l = 0; l < 2; l++) begin
                int v = int'((x >> (16 * l)) & 32'hFFFF);
                int r;
                if (kind == 3 && v >= 32768) v = v - 65536;
                r = (kind == 0) ? (v << amt) : (v >>> amt);
                res[16*l +: 16] = r[15:0];
            end
        end
        return res;
    endfunction

    function automatic logic [31:0] mk(logic [5:0] maj, logic [4:0] rs,
                                      logic [2:0] sub, logic [3:0] xd, logic [3:0] xa);
        return {6'h1C, rs, sub, xd, xa, 4'h0, maj};
    endfunction

    // Drive one cycle at a falling edge, model it, compare at the next one.
    task automatic step(bit v, logic [31:0] ins, logic [31:0] a, logic [31:0] d, logic [31:0] g);
        exp_t e;
        bit   hit, legal;
        int   sub;
        int   amt;
        in_valid = v; instr = ins; xra_val = a; xrd_val = d; gpr_val = g;
        hit   = v && ins[5:0] == 6'h36;
        sub   = int'(ins[20:18]);
        legal = hit && sub != 2 && sub != 6;
        amt   = int'(g[3:0]);                     // R5: only the low four bits count
        if (legal) begin
            m_ai = ins[13:10]; m_di = ins[17:14];
            m_ra = ref_shift(a, amt, sub);
            m_rd = ref_shift(d, amt, sub);
        end
        e.we = legal; e.rsv = hit && !legal;
        e.ai = m_ai; e.di = m_di; e.ra = m_ra; e.rd = m_rd;
        if (!hit)            e.tag = "R1";
        else if (!legal)     e.tag = "R3";
        else if (amt == 0)   e.tag = "R8";
        else if (sub >= 4)   e.tag = "R2 R7";
        else                 e.tag = "R2 R6";
        q.push_back(e);
        #1 chk("R4 gpr index", 32'(gpr_rd_idx), 32'(ins[25:21]));
        @(negedge clk);
        e = q.pop_front();
        chk({e.tag, " R9 we"}, 32'(out_we), 32'(e.we));
        chk({e.tag, " rsv"}, 32'(out_rsv), 32'(e.rsv));
        chk({e.tag, " R4 a idx"}, 32'(out_xra_idx), 32'(e.ai));
        chk({e.tag, " R4 d idx"}, 32'(out_xrd_idx), 32'(e.di));
        chk({e.tag, " a res"}, out_xra_res, e.ra);
        chk({e.tag, " d res"}, out_xrd_res, e.rd);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int ops[6] = '{0, 1, 3, 4, 5, 7};
        @(negedge clk); @(negedge clk);
        // R10: reset clears all registered outputs
        chk("R10 we", 32'(out_we), 0);
        chk("R10 rsv", 32'(out_rsv), 0);
        chk("R10 a res", out_xra_res, 0);
        chk("R10 d res", out_xrd_res, 0);
        chk("R10 idx", 32'({out_xra_idx, out_xrd_idx}), 0);
        rst_n = 1'b1;

        // R2 R6 R7 R8: all six operations at every amount, negative lanes included
        foreach (ops[i]) begin
            for (int s = 0; s < 16; s++) begin
                logic [31:0] g = ($urandom & 32'hFFFF_FFF0) | 32'(s);   // R5
                step(1, mk(6'h36, 5'($urandom), 3'(ops[i]), 4'($urandom), 4'($urandom)),
                     $urandom, $urandom | 32'h8000_8000, g);
            end
        end
        // R7: lane boundary patterns
        step(1, mk(6'h36, 5'd3, 3'd4, 4'd1, 4'd2), 32'h0001_8000, 32'hFFFF_FFFF, 32'd15);
        step(1, mk(6'h36, 5'd3, 3'd7, 4'd1, 4'd2), 32'h7FFF_8000, 32'h8000_7FFF, 32'd15);
        step(1, mk(6'h36, 5'd3, 3'd5, 4'd1, 4'd2), 32'h8000_8000, 32'hFFFF_0001, 32'd1);
        // R5: upper amount bits set, low bits zero means no shift
        step(1, mk(6'h36, 5'd9, 3'd0, 4'd5, 4'd6), 32'h1234_5678, 32'h9ABC_DEF0, 32'hFFFF_FFF0);
        // R3: undefined codes trap and keep outputs
        step(1, mk(6'h36, 5'd1, 3'd2, 4'd7, 4'd8), $urandom, $urandom, 32'd3);
        step(1, mk(6'h36, 5'd1, 3'd6, 4'd7, 4'd8), $urandom, $urandom, 32'd3);
        // R1: foreign major opcode and invalid cycle do nothing
        step(1, mk(6'h34, 5'd2, 3'd0, 4'd3, 4'd4), $urandom, $urandom, 32'd2);
        step(0, mk(6'h36, 5'd2, 3'd0, 4'd3, 4'd4), $urandom, $urandom, 32'd2);
        // R9: back-to-back then idle
        step(1, mk(6'h36, 5'd4, 3'd1, 4'd9, 4'd10), 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'd4);
        step(1, mk(6'h36, 5'd4, 3'd3, 4'd11, 4'd12), 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'd4);
        step(0, '0, '0, '0, '0);

        // Random mix of all encodings
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] maj = ($urandom % 10 == 0) ? 6'($urandom) : 6'h36;
            step(($urandom % 8) != 0,
                 mk(maj, 5'($urandom), 3'($urandom), 4'($urandom), 4'($urandom)),
                 $urandom, $urandom, $urandom);
        end
        finish_run();
    end

endmodule